// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block owns the two row and column strobes of an asynchronous page-mode DRAM whenever the memory is not serving ordinary accesses. After reset it holds both strobes inactive for a programmable quiet period counted in clock cycles. It then runs a train of CAS-before-RAS cycles that seeds the device's internal row counter, and only after that does it report the memory as ready. From then on an interval timer raises a refresh request toward the access arbiter. Once the arbiter grants, the sequencer drives the strobes and shows them as busy until the refresh work is done.

A mode input selects between two refresh styles. In distributed style a single CAS-before-RAS cycle is due every interval. In burst style a full sweep of every row is due once per interval times the row count. The same input decides how a self-refresh period is bracketed. When refresh has been distributed, the sequencer enters self-refresh straight away and issues one cycle on exit. In burst style it sweeps all rows just before entry and again just after exit. Self-refresh is held for as long as the request input stays high, and it is acknowledged while the strobes are parked low.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, ras_n_o and cas_n_o are high and ready_o, ref_req_o, ref_busy_o and sr_ack_o are low.
- R2: Neither strobe goes low during the first PAUSE_CYC clock cycles after reset is released.
- R3: After the pause, exactly INIT_CYC CAS-before-RAS cycles are issued before ready_o rises, and ready_o stays low until they are complete.
- R4: RAS never falls while CAS is high, and CAS has been low for at least T_CSR cycles when RAS falls (CAS-before-RAS order only).
- R5: Every RAS-low period lasts at least T_RAS cycles, and every RAS-high gap between two cycles lasts at least T_RP cycles.
- R6: With distrib_mode_i = 1, ref_req_o rises once every INTERVAL cycles. No strobe activity starts while the request is not granted, and a grant yields exactly one CAS-before-RAS cycle.
- R7: With distrib_mode_i = 0, a grant of ref_req_o yields exactly ROWS CAS-before-RAS cycles.
- R8: ref_busy_o is high in every cycle in which either strobe is low.
- R9: A self-refresh request accepted with distrib_mode_i = 1 goes straight to a single CAS-before-RAS entry with no sweep before it. Both strobes then stay low, with sr_ack_o high, for as long as sr_req_i stays high.
- R10: With distrib_mode_i = 1, exactly one CAS-before-RAS cycle follows self-refresh exit. With distrib_mode_i = 0, exactly ROWS cycles come before the entry cycle and exactly ROWS follow the exit.
- R11: ready_o is low from the acceptance of a self-refresh request until the cycles after exit are complete, and it then returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| distrib_mode_i | input | 1 | 1 = distributed refresh, 0 = burst refresh |
| ref_gnt_i | input | 1 | Arbiter grant for a pending refresh |
| sr_req_i | input | 1 | Self-refresh request; level held for the whole period |
| ref_req_o | output | 1 | Refresh is due |
| ref_busy_o | output | 1 | Sequencer owns the strobes |
| ready_o | output | 1 | Memory available for normal accesses |
| sr_ack_o | output | 1 | Device parked in self-refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |

## Verification
The bench builds the block with a 200-cycle pause, 16 rows, a 100-cycle interval and strobe timings of 2, 5 and 4 cycles. With these values a full row sweep takes under two hundred cycles and a burst period about sixteen hundred. The initialization count, both sweeps around self-refresh and the exact interval spacing can therefore all be counted edge by edge in a short run. A port monitor counts every RAS fall and measures every strobe width against the configured minimums.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    SQ_PAUSE,
    SQ_INIT,
    SQ_IDLE,
    SQ_REF,
    SQ_PRE,
    SQ_SELF,
    SQ_POST
  } seq_st_e;

  typedef enum logic [1:0] {
    EG_IDLE,
    EG_CSR,
    EG_RAS,
    EG_RP
  } eng_st_e;

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W'(RST_VAL);
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dram_strobe_engine.sv
module dram_strobe_engine
  import dram_seq_pkg::*;
#(
  parameter int unsigned T_CSR = 3,
  parameter int unsigned T_RAS = 15,
  parameter int unsigned T_RP  = 12,
  parameter int unsigned CW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          hold_i,
  output logic          ras_n_o,
  output logic          cas_n_o,
  output logic          done_o
);

  localparam int unsigned TMAX0 = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int unsigned TMAX  = (TMAX0 > T_RP) ? TMAX0 : T_RP;
  localparam int unsigned TW    = $clog2(TMAX + 1);

  eng_st_e       st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          t_zero;

  assign t_zero = (tcnt_q == '0);
  assign done_o = (st_q == EG_RP) && t_zero && (rem_q == CW'(1));

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    rem_d  = rem_q;
    unique case (st_q)
      EG_IDLE: begin
        if (start_i) begin
          st_d   = EG_CSR;
          tcnt_d = TW'(T_CSR - 1);
          rem_d  = count_i;
        end
      end
      EG_CSR: begin
        if (t_zero) begin
          st_d   = EG_RAS;
          tcnt_d = TW'(T_RAS - 1);
        end else begin
          tcnt_d = tcnt_q - TW'(1);
        end
      end
      EG_RAS: begin
        if (!t_zero) begin
          tcnt_d = tcnt_q - TW'(1);
        end else if (!hold_i) begin
          st_d   = EG_RP;
          tcnt_d = TW'(T_RP - 1);
        end
      end
      EG_RP: begin
        if (!t_zero) begin
          tcnt_d = tcnt_q - TW'(1);
        end else if (rem_q > CW'(1)) begin
          st_d   = EG_CSR;
          tcnt_d = TW'(T_CSR - 1);
          rem_d  = rem_q - CW'(1);
        end else if (start_i) begin
          st_d   = EG_CSR;
          tcnt_d = TW'(T_CSR - 1);
          rem_d  = count_i;
        end else begin
          st_d = EG_IDLE;
        end
      end
      default: st_d = EG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EG_IDLE;
      tcnt_q <= '0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      rem_q  <= rem_d;
    end
  end

  assign cas_n_o = !((st_q == EG_CSR) || (st_q == EG_RAS));
  assign ras_n_o = !(st_q == EG_RAS);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 50000,
  parameter int unsigned INIT_CYC  = 8,
  parameter int unsigned ROWS      = 4096,
  parameter int unsigned INTERVAL  = 3900,
  parameter int unsigned T_CSR     = 3,
  parameter int unsigned T_RAS     = 15,
  parameter int unsigned T_RP      = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic distrib_mode_i,
  input  logic ref_gnt_i,
  input  logic sr_req_i,
  output logic ref_req_o,
  output logic ref_busy_o,
  output logic ready_o,
  output logic sr_ack_o,
  output logic ras_n_o,
  output logic cas_n_o
);

  localparam int unsigned CMAX  = (ROWS > INIT_CYC) ? ROWS : INIT_CYC;
  localparam int unsigned CW    = $clog2(CMAX + 1);
  localparam int unsigned PW    = $clog2(PAUSE_CYC + 1);
  localparam int unsigned PER_D = INTERVAL;
  localparam int unsigned PER_B = INTERVAL * ROWS;
  localparam int unsigned IW    = $clog2(PER_B + 1);

  seq_st_e       st_q, st_d;
  logic          pend_q, pend_d;
  logic          pol_q, pol_d;
  logic          eng_start;
  logic [CW-1:0] eng_count;
  logic          eng_hold;
  logic          eng_done;
  logic          pause_zero;
  logic          iv_run, iv_zero, iv_load, iv_expire;
  logic [IW-1:0] iv_period;

  // power-up quiet period
  dram_seq_timer #(
    .W       (PW),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_pause (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (1'b0),
    .load_val_i ('0),
    .en_i       (st_q == SQ_PAUSE),
    .zero_o     (pause_zero)
  );

  // periodic refresh interval
  assign iv_run    = (st_q == SQ_IDLE) || (st_q == SQ_REF);
  assign iv_expire = iv_run && iv_zero;
  assign iv_load   = iv_expire || !iv_run;
  assign iv_period = distrib_mode_i ? IW'(PER_D - 1) : IW'(PER_B - 1);

  dram_seq_timer #(
    .W       (IW),
    .RST_VAL (PER_D - 1)
  ) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (iv_load),
    .load_val_i (iv_period),
    .en_i       (iv_run),
    .zero_o     (iv_zero)
  );

  assign eng_hold = (st_q == SQ_SELF) && sr_req_i;

  dram_strobe_engine #(
    .T_CSR (T_CSR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP),
    .CW    (CW)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (eng_start),
    .count_i (eng_count),
    .hold_i  (eng_hold),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .done_o  (eng_done)
  );

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q || iv_expire;
    pol_d     = pol_q;
    eng_start = 1'b0;
    eng_count = CW'(1);
    unique case (st_q)
      SQ_PAUSE: begin
        if (pause_zero) begin
          st_d      = SQ_INIT;
          eng_start = 1'b1;
          eng_count = CW'(INIT_CYC);
        end
      end
      SQ_INIT: begin
        if (eng_done) st_d = SQ_IDLE;
      end
      SQ_IDLE: begin
        if (sr_req_i) begin
          pend_d    = 1'b0;
          pol_d     = distrib_mode_i;
          eng_start = 1'b1;
          if (distrib_mode_i) begin
            st_d      = SQ_SELF;
            eng_count = CW'(1);
          end else begin
            st_d      = SQ_PRE;
            eng_count = CW'(ROWS);
          end
        end else if (pend_q && ref_gnt_i) begin
          st_d      = SQ_REF;
          pend_d    = 1'b0;
          eng_start = 1'b1;
          eng_count = distrib_mode_i ? CW'(1) : CW'(ROWS);
        end
      end
      SQ_REF: begin
        if (eng_done) st_d = SQ_IDLE;
      end
      SQ_PRE: begin
        if (eng_done) begin
          st_d      = SQ_SELF;
          eng_start = 1'b1;
          eng_count = CW'(1);
        end
      end
      SQ_SELF: begin
        if (eng_done) begin
          st_d      = SQ_POST;
          eng_start = 1'b1;
          eng_count = pol_q ? CW'(1) : CW'(ROWS);
        end
      end
      SQ_POST: begin
        pend_d = 1'b0;
        if (eng_done) st_d = SQ_IDLE;
      end
      default: st_d = SQ_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_PAUSE;
      pend_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      pol_q  <= pol_d;
    end
  end

  assign ref_req_o  = pend_q;
  assign ready_o    = (st_q == SQ_IDLE) || (st_q == SQ_REF);
  assign ref_busy_o = (st_q != SQ_IDLE) && (st_q != SQ_PAUSE);
  assign sr_ack_o   = (st_q == SQ_SELF) && !ras_n_o;

endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
  parameter int unsigned PAUSE_CYC = 50000,
  parameter int unsigned T_RAS     = 15
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic ready_o,
  input logic ref_busy_o,
  input logic sr_ack_o
);

  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned RW = $clog2(T_RAS + 1);

  logic [PW-1:0] since_rst_q;
  logic [RW-1:0] ras_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst_q <= '0;
      ras_low_q   <= '0;
    end else begin
      if (since_rst_q < PW'(PAUSE_CYC)) since_rst_q <= since_rst_q + PW'(1);
      if (ras_n_o) ras_low_q <= '0;
      else if (ras_low_q < RW'(T_RAS)) ras_low_q <= ras_low_q + RW'(1);
    end
  end

  // R2
  no_early_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q < PW'(PAUSE_CYC)) |-> (ras_n_o && cas_n_o));

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> (ras_low_q >= RW'(T_RAS)));

  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o || !cas_n_o) |-> ref_busy_o);

  // R9
  sr_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_ack_o |-> (!ras_n_o && !cas_n_o));

  // R11
  sr_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_ack_o |-> !ready_o);

endmodule

bind dram_refresh_seq dram_seq_checker #(
  .PAUSE_CYC (PAUSE_CYC),
  .T_RAS     (T_RAS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .ready_o    (ready_o),
  .ref_busy_o (ref_busy_o),
  .sr_ack_o   (sr_ack_o)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;

  localparam int PAUSE_CYC = 200;
  localparam int INIT_CYC  = 8;
  localparam int ROWS      = 16;
  localparam int INTERVAL  = 100;
  localparam int T_CSR     = 2;
  localparam int T_RAS     = 5;
  localparam int T_RP      = 4;

  logic clk;
  logic rst_n;
  logic distrib_mode_i, ref_gnt_i, sr_req_i;
  logic ref_req_o, ref_busy_o, ready_o, sr_ack_o, ras_n_o, cas_n_o;

  int checks;
  int fails;
  int cyc;
  int cbr_cnt;
  int cas_low_run, ras_low_run, ras_high_run;
  int first_cas_cyc;
  logic prev_ras;
  logic seen_fall;

  dram_refresh_seq #(
    .PAUSE_CYC (PAUSE_CYC),
    .INIT_CYC  (INIT_CYC),
    .ROWS      (ROWS),
    .INTERVAL  (INTERVAL),
    .T_CSR     (T_CSR),
    .T_RAS     (T_RAS),
    .T_RP      (T_RP)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .distrib_mode_i (distrib_mode_i),
    .ref_gnt_i      (ref_gnt_i),
    .sr_req_i       (sr_req_i),
    .ref_req_o      (ref_req_o),
    .ref_busy_o     (ref_busy_o),
    .ready_o        (ready_o),
    .sr_ack_o       (sr_ack_o),
    .ras_n_o        (ras_n_o),
    .cas_n_o        (cas_n_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor: strobe order and widths (R4, R5, R8), pause (R2)
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; cas_low_run = 0; ras_low_run = 0; ras_high_run = 0;
      prev_ras = 1'b1; seen_fall = 1'b0; first_cas_cyc = -1;
    end else begin
      cyc++;
      if (!cas_n_o && first_cas_cyc < 0) first_cas_cyc = cyc;
      if ((!ras_n_o || !cas_n_o) && !ref_busy_o)
        check(1'b0, "R8 busy while strobe low", 0, 1);
      if (prev_ras && !ras_n_o) begin
        cbr_cnt++;
        check(!cas_n_o && cas_low_run >= T_CSR, "R4 CAS lead before RAS fall", cas_low_run, T_CSR);
        if (seen_fall) check(ras_high_run >= T_RP, "R5 RAS precharge", ras_high_run, T_RP);
        seen_fall = 1'b1;
      end
      if (!prev_ras && ras_n_o)
        check(ras_low_run >= T_RAS, "R5 RAS low width", ras_low_run, T_RAS);
      cas_low_run  = cas_n_o ? 0 : cas_low_run + 1;
      ras_low_run  = ras_n_o ? 0 : ras_low_run + 1;
      ras_high_run = ras_n_o ? ras_high_run + 1 : 0;
      prev_ras = ras_n_o;
    end
  end

  task automatic t_reset;
    @(negedge clk);
    // R1
    check(ras_n_o && cas_n_o, "R1 strobes high in reset", {ras_n_o, cas_n_o}, 3);
    check(!ready_o && !ref_req_o && !ref_busy_o && !sr_ack_o, "R1 flags low in reset",
          {ready_o, ref_req_o, ref_busy_o, sr_ack_o}, 0);
  endtask

  task automatic t_pause_init;
    int lo_ready_viol;
    lo_ready_viol = 0;
    while (!ready_o) begin
      @(negedge clk);
      if (cbr_cnt < INIT_CYC && ready_o) lo_ready_viol++;
    end
    // R2
    check(first_cas_cyc > PAUSE_CYC, "R2 quiet pause", first_cas_cyc, PAUSE_CYC + 1);
    // R3
    check(cbr_cnt == INIT_CYC, "R3 init cycle count", cbr_cnt, INIT_CYC);
    check(lo_ready_viol == 0, "R3 ready low during init", lo_ready_viol, 0);
  endtask

  task automatic t_distrib;
    int c0;
    distrib_mode_i = 1'b1; ref_gnt_i = 1'b0;
    while (!ref_req_o) @(negedge clk);
    c0 = cbr_cnt;
    repeat (30) @(negedge clk);
    // R6 no strobes without grant
    check(cbr_cnt == c0 && ras_n_o && cas_n_o, "R6 held off without grant", cbr_cnt - c0, 0);
    ref_gnt_i = 1'b1;
    while (ref_req_o) @(negedge clk);
    ref_gnt_i = 1'b0;
    repeat (20) @(negedge clk);
    check(cbr_cnt - c0 == 1, "R6 one cycle per grant", cbr_cnt - c0, 1);
  endtask

  task automatic t_interval;
    int t1;
    logic pr;
    distrib_mode_i = 1'b1; ref_gnt_i = 1'b1;
    pr = ref_req_o; t1 = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ref_req_o && !pr) begin
        if (t1 >= 0) begin
          // R6 spacing
          check(cyc - t1 == INTERVAL, "R6 request spacing", cyc - t1, INTERVAL);
          break;
        end
        t1 = cyc;
      end
      pr = ref_req_o;
    end
    check(t1 >= 0, "R6 request seen", t1, 0);
    ref_gnt_i = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_burst;
    int c0;
    distrib_mode_i = 1'b0; ref_gnt_i = 1'b0;
    repeat (2) @(negedge clk);
    while (ref_req_o) begin ref_gnt_i = 1'b1; @(negedge clk); end
    ref_gnt_i = 1'b0;
    repeat (200) @(negedge clk);
    while (!ref_req_o) @(negedge clk);
    c0 = cbr_cnt;
    ref_gnt_i = 1'b1;
    while (ref_req_o) @(negedge clk);
    ref_gnt_i = 1'b0;
    repeat (ROWS * (T_CSR + T_RAS + T_RP) + 20) @(negedge clk);
    // R7
    check(cbr_cnt - c0 == ROWS, "R7 burst sweep length", cbr_cnt - c0, ROWS);
  endtask

  task automatic t_self(input logic dmode);
    int c0, c1, c2, viol;
    distrib_mode_i = dmode; ref_gnt_i = 1'b0; viol = 0;
    @(posedge clk); c0 = cbr_cnt;
    @(negedge clk); sr_req_i = 1'b1;
    while (!sr_ack_o) begin
      @(negedge clk);
      if (ready_o) viol++;
    end
    @(posedge clk); c1 = cbr_cnt;
    // R9 / R10 entry
    check(c1 - c0 == (dmode ? 1 : ROWS + 1),
          dmode ? "R9 no pre-sweep" : "R10 pre-sweep", c1 - c0, dmode ? 1 : ROWS + 1);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!sr_ack_o || ras_n_o || cas_n_o || ready_o) viol++;
    end
    check(viol == 0, "R9 held in self-refresh, R11 not ready", viol, 0);
    sr_req_i = 1'b0;
    viol = 0;
    while (!ready_o) begin
      @(negedge clk);
      if (sr_ack_o && ready_o) viol++;
    end
    @(posedge clk); c2 = cbr_cnt;
    // R10
    check(c2 - c1 == (dmode ? 1 : ROWS), "R10 post-exit cycles", c2 - c1, dmode ? 1 : ROWS);
    // R11
    check(ready_o && viol == 0, "R11 ready back after exit", ready_o, 1);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; cbr_cnt = 0;
    rst_n = 1'b0; distrib_mode_i = 1'b1; ref_gnt_i = 1'b0; sr_req_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_pause_init();
    t_distrib();
    t_interval();
    t_burst();
    t_self(1'b0);
    t_self(1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule